// File: doc/BRIEF.md
# Self-Starting Six-State Twisted-Ring Counter

This block is a three-bit synchronous counter. Out of reset it steps through six codes: 000, 100, 110, 111, 011, 001, and then starts again at 000. This is the pattern of a twisted-ring (Johnson) shift register. The bits shift from Q2 towards Q0, and the inverse of Q0 feeds back into Q2. The output `q` carries the code as Q2Q1Q0, with `q[2]` as Q2.

Two codes, 010 and 101, are not part of the six-code cycle. Plain shift-and-invert logic would send each of these to the other, forever. This design changes the Q0 next-state term so that 101 goes to 011. As a result, any code the flip-flops power up in, or are upset into, reaches the main cycle within two clocks.

The reset value is a parameter. Its default is 000. Setting it to another code makes the counter start from that code, which lets a chosen start code be examined.

Top module: `twist6_counter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `q` loads `INIT_CODE` (default 000) on that edge.
- R2: With `rst` low, each rising edge moves `q` one step along the main cycle: 000 to 100, 100 to 110, 110 to 111, 111 to 011, 011 to 001, and 001 back to 000. The cycle period is six clocks.
- R3: With `rst` low, unused code 010 moves to 101 on the next edge.
- R4: With `rst` low, unused code 101 moves to 011 on the next edge. The two unused codes therefore never alternate with each other.
- R5: Starting from any code, the counter is in the main cycle after at most two clocks. From 010 the path is 101, then 011.
- R6: In every state, the next Q1 equals the present Q2, and the next Q2 equals the inverse of the present Q0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| q | output | 3 | Counter state Q2Q1Q0 |

## Verification
The counter cannot be loaded, so the bench builds extra instances whose reset value is 010 or 101. This is the only way to reach the unused codes.

- A design that kept the plain shift logic would move from 101 to 010. It would then stay in that pair and never show 011.
- A design that redirected the wrong term would break the 001-to-000 wrap, or one of the main steps, in the table walk.

A reset applied in the middle of a run is also checked. A design that ignored reset mid-sequence would keep counting instead of returning to the reset code.

// File: rtl/twist6_counter.sv
module twist6_counter #(
  parameter logic [2:0] INIT_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] q
);

  logic [2:0] nxt;

  // shift towards bit 0, inverted feedback into bit 2;
  // the q[2]&q[0] term steers 101 to 011 instead of 010
  assign nxt[2] = ~q[0];
  assign nxt[1] = q[2];
  assign nxt[0] = q[1] | (q[2] & q[0]);

  always_ff @(posedge clk) begin
    if (rst) q <= INIT_CODE;
    else     q <= nxt;
  end

endmodule

// File: rtl/twist6_counter_chk.sv
module twist6_counter_chk #(
  parameter logic [2:0] INIT_CODE = 3'b000
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] q
);

  p_reset_load_r1: assert property (@(posedge clk) rst |=> q == INIT_CODE);

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    q == 3'b001 |=> q == 3'b000);

  p_peak_r2: assert property (@(posedge clk) disable iff (rst)
    q == 3'b111 |=> q == 3'b011);

  p_unused_lo_r3: assert property (@(posedge clk) disable iff (rst)
    q == 3'b010 |=> q == 3'b101);

  p_redirect_r4: assert property (@(posedge clk) disable iff (rst)
    q == 3'b101 |=> q == 3'b011);

  p_no_pair_loop_r5: assert property (@(posedge clk) disable iff (rst)
    q == 3'b101 |=> q != 3'b010);

  p_shift_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q[1] == $past(q[2])) && (q[2] == !$past(q[0])));

endmodule

bind twist6_counter twist6_counter_chk #(.INIT_CODE(INIT_CODE)) u_chk (
  .clk(clk), .rst(rst), .q(q)
);

// File: tb/sim_twist6_counter.sv
`timescale 1ns/1ps
module sim_twist6_counter;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] q0, q1, q2;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  twist6_counter #(.INIT_CODE(3'b000)) u0 (.clk(clk), .rst(rst), .q(q0));
  twist6_counter #(.INIT_CODE(3'b010)) u1 (.clk(clk), .rst(rst), .q(q1));
  twist6_counter #(.INIT_CODE(3'b101)) u2 (.clk(clk), .rst(rst), .q(q2));

  localparam logic [2:0] RING [6] = '{3'b000, 3'b100, 3'b110, 3'b111, 3'b011, 3'b001};

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step();
    step();
    check(q0, 3'b000, "R1 reset default");
    check(q1, 3'b010, "R1 reset param 010");
    check(q2, 3'b101, "R1 reset param 101");
    rst = 1'b0;

    // R2 R6: main cycle walked for two full periods
    for (int i = 1; i <= 13; i++) begin
      step();
      check(q0, RING[i % 6], "R2 main cycle");
      if (i == 1) begin
        check(q1, 3'b101, "R3 010 to 101");
        check(q2, 3'b011, "R4 101 to 011");
      end
      if (i == 2) begin
        check(q1, 3'b011, "R5 010 enters ring in two");
        check(q2, 3'b001, "R5 101 stays in ring");
      end
      if (i == 3) check(q1, 3'b001, "R6 shift after entry");
    end

    // R1: reset applied in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    step();
    check(q0, 3'b000, "R1 mid-run reset");
    check(q1, 3'b010, "R1 mid-run reset 010");
    rst = 1'b0;
    step();
    check(q0, 3'b100, "R2 restart after reset");
    check(q1, 3'b101, "R3 010 to 101 again");
    step();
    check(q1, 3'b011, "R4 no return to 010");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule